// File: doc/BRIEF.md
# Nesting Interrupt Controller

This block gathers ten interrupt sources (a non-maskable line, four maskable external pins, two DMA-complete lines and three timer lines) and decides which one the CPU should service next. Every maskable source carries its own 3-bit priority and its own mask bit. The non-maskable line outranks all of them. A source that is already in service blocks every request of equal or lower rank, so a more urgent request can nest on top of a running handler and a less urgent one has to wait.

The CPU sees a request line and a vector type. It answers with a one-cycle acknowledge, and the controller then marks that source in service. Software retires the most urgent in-service source with an end-of-interrupt write. As an alternative, software can switch the maskable sources to polled service. It then reads a poll register that names the winning source and claims it in the same access.

The handshake is a three-state machine:
- S_IDLE goes to S_REQ when a forwardable request exists.
- S_REQ goes to S_ACKED on acknowledge.
- S_REQ falls back to S_IDLE (withdraw) when the request vanishes before acknowledge.
- S_ACKED always returns to S_IDLE after one cycle.

Top module: `ipc_nest_ctrl`

## Requirements
- R1: After reset, irq_o is low, MASK (addr 0) reads 0x01FF, MODE (addr 1) reads 0, PRIA (addr 2) reads 0x7FFF, PRIB (addr 3) reads 0x0FFF, and PEND (addr 6) and INSV (addr 7) read 0.
- R2: The source numbering is fixed: 0 non-maskable, 1..4 external pins 0..3, 5..6 DMA 0..1, 7..9 timer 0..2. Bit n of PEND and INSV belongs to source n. Sources 0 and 5..9, and external pins in edge mode, latch pending on a rising input edge, even after a one-cycle pulse. The pending bit clears when that source is acknowledged or claimed by a poll.
- R3: MODE bit n (n = 0..3) puts external pin n into level mode. Its pending bit then follows the pin, and acknowledge does not clear it.
- R4: MASK bit s-1 set stops maskable source s from being forwarded, but its pending bit still records the request. Clearing the mask bit lets it through.
- R5: Source s has priority PRIA[3(s-1)+2:3(s-1)] for s = 1..5 and PRIB[3(s-6)+2:3(s-6)] for s = 6..9, with 0 the most urgent. When priorities are equal, the lower source number wins.
- R6: Source 0 cannot be masked, outranks every maskable source, and raises irq_o even in polled mode.
- R7: A pending source is forwarded only if its rank is strictly more urgent than every in-service source. A more urgent request nests over a running one.
- R8: While irq_o is high, irq_type_o = VEC_BASE (default 0x20) + source number. An acknowledge sets that source's INSV bit and drops irq_o for at least one cycle.
- R9: Writing EOI (addr 4) clears only the most urgent in-service bit.
- R10: MODE bit 4 selects polled mode, in which no maskable source raises irq_o.
- R11: Reading POLL (addr 5) returns bit 15 = valid and bits 3:0 = source, the same choice that R7 would forward. A valid read marks the source in service and clears its edge pending. An invalid read returns 0x0000.
- R12: If a forwarded request disappears before acknowledge, irq_o drops again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request (source 0) |
| ext_i | input | 4 | External maskable requests (sources 1..4) |
| dma_i | input | 2 | DMA completion lines (sources 5..6) |
| tmr_i | input | 3 | Timer lines (sources 7..9) |
| inta_i | input | 1 | CPU acknowledge, one cycle |
| irq_o | output | 1 | Interrupt request to CPU |
| irq_type_o | output | 8 | Vector type of the offered source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (claims on POLL) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |

## Verification
The bench raises two requests in the same cycle with different priorities, and again with equal priorities. A resolver that breaks ties the wrong way, or that uses "not less urgent" instead of "strictly more urgent", would take them in the wrong order or nest a peer over its twin. It retires one of two nested handlers with an end-of-interrupt and checks which bit survives; a design that cleared the oldest or all in-service bits would show the wrong INSV. It drops a level request before acknowledge and expects irq_o to fall, which catches a handshake that latches a stale vector. It also polls a timer in polled mode, where a design that did not claim on the read would leave the source pending and offer it again.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int NSRC  = 10;               // total sources
    localparam int NEXT  = 4;                // pins with selectable trigger
    localparam int PW    = 3;                // priority field width
    localparam int RW    = PW + 1;           // internal rank width
    localparam int SW    = $clog2(NSRC);     // source number width
    localparam int DW    = 16;               // register data width
    localparam int AW    = 3;                // register address width
    localparam int NPA   = 5;                // sources held in PRIA
    localparam int NPB   = NSRC - 1 - NPA;   // sources held in PRIB
    localparam int PAW   = NPA * PW;
    localparam int PBW   = NPB * PW;
    localparam int POLLB = NEXT;             // MODE bit selecting polled service

    typedef enum logic [AW-1:0] {
        A_MASK = 3'd0,
        A_MODE = 3'd1,
        A_PRIA = 3'd2,
        A_PRIB = 3'd3,
        A_EOI  = 3'd4,
        A_POLL = 3'd5,
        A_PEND = 3'd6,
        A_INSV = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REQ   = 2'd1,
        S_ACKED = 2'd2
    } hs_state_e;
endpackage

// File: rtl/ipc_src_latch.sv
module ipc_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic level_i,
    input  logic clr_i,
    output logic pend_o
);
    logic req_q;
    logic pend_q;
    logic rise;

    assign rise = req_i & ~req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            req_q <= req_i;
            if (level_i)
                pend_q <= 1'b0;
            else
                pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    assign pend_o = level_i ? req_i : pend_q;

    // a fresh edge in edge mode is never lost, even against a same-cycle clear
    assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !level_i) |=> pend_q)
        else $error("edge not latched");
endmodule

// File: rtl/ipc_rank_pick.sv
module ipc_rank_pick #(
    parameter int N  = 10,
    parameter int RW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    req_i,
    input  logic [N*RW-1:0] rank_flat_i,
    output logic            valid_o,
    output logic [IW-1:0]   idx_o,
    output logic [RW-1:0]   rank_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        rank_o  = '1;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!valid_o || (rank_flat_i[i*RW +: RW] < rank_o))) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                rank_o  = rank_flat_i[i*RW +: RW];
            end
        end
    end
endmodule

// File: rtl/ipc_cfg_regs.sv
module ipc_cfg_regs
    import ipc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [AW-1:0]            addr_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [NSRC-2:0]          mask_o,
    output logic [NEXT-1:0]          level_o,
    output logic                     poll_o,
    output logic [PAW-1:0]           prio_a_o,
    output logic [PBW-1:0]           prio_b_o,
    output logic [NSRC-1:0][PW-1:0]  prio_o,
    output logic                     eoi_o
);
    reg_addr_e addr;
    logic      unused_bits;

    assign addr        = reg_addr_e'(addr_i);
    assign unused_bits = wdata_i[DW-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o   <= '1;
            level_o  <= '0;
            poll_o   <= 1'b0;
            prio_a_o <= '1;
            prio_b_o <= '1;
        end else if (wr_i) begin
            unique case (addr)
                A_MASK:  mask_o   <= wdata_i[NSRC-2:0];
                A_MODE: begin
                         level_o  <= wdata_i[NEXT-1:0];
                         poll_o   <= wdata_i[POLLB];
                end
                A_PRIA:  prio_a_o <= wdata_i[PAW-1:0];
                A_PRIB:  prio_b_o <= wdata_i[PBW-1:0];
                default: ;
            endcase
        end
    end

    assign eoi_o = wr_i && (addr == A_EOI);

    assign prio_o[0] = '0;
    for (genvar s = 1; s < NSRC; s++) begin : g_prio
        if (s <= NPA) begin : g_a
            assign prio_o[s] = prio_a_o[(s-1)*PW +: PW];
        end else begin : g_b
            assign prio_o[s] = prio_b_o[(s-1-NPA)*PW +: PW];
        end
    end
endmodule

// File: rtl/ipc_nest_ctrl.sv
module ipc_nest_ctrl
    import ipc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_i,
    input  logic [3:0]    ext_i,
    input  logic [1:0]    dma_i,
    input  logic [2:0]    tmr_i,
    input  logic          inta_i,
    output logic          irq_o,
    output logic [7:0]    irq_type_o,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic [2:0]    reg_addr_i,
    input  logic [15:0]   reg_wdata_i,
    output logic [15:0]   reg_rdata_o
);
    // ---------------- configuration ----------------
    logic [NSRC-2:0]         mask;
    logic [NEXT-1:0]         level_cfg;
    logic                    poll_mode;
    logic [PAW-1:0]          prio_a;
    logic [PBW-1:0]          prio_b;
    logic [NSRC-1:0][PW-1:0] prio;
    logic                    eoi;

    ipc_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .mask_o   (mask),
        .level_o  (level_cfg),
        .poll_o   (poll_mode),
        .prio_a_o (prio_a),
        .prio_b_o (prio_b),
        .prio_o   (prio),
        .eoi_o    (eoi)
    );

    // ---------------- source capture ----------------
    logic [NSRC-1:0] src_in;
    logic [NSRC-1:0] src_lvl;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] clr_vec;

    assign src_in = {tmr_i, dma_i, ext_i, nmi_i};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s >= 1 && s <= NEXT) begin : g_sel
            assign src_lvl[s] = level_cfg[s-1];
        end else begin : g_edge
            assign src_lvl[s] = 1'b0;
        end
        ipc_src_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (src_in[s]),
            .level_i (src_lvl[s]),
            .clr_i   (clr_vec[s]),
            .pend_o  (pend[s])
        );
    end

    // ---------------- ranking ----------------
    logic [NSRC*RW-1:0] rank_flat;
    logic [NSRC-1:0]    enable;

    for (genvar s = 0; s < NSRC; s++) begin : g_rank
        if (s == 0) begin : g_nmi
            assign rank_flat[s*RW +: RW] = '0;
            assign enable[s]             = 1'b1;
        end else begin : g_mk
            assign rank_flat[s*RW +: RW] = RW'(prio[s]) + RW'(1);
            assign enable[s]             = ~mask[s-1];
        end
    end

    logic [NSRC-1:0] isr_q;
    logic            cand_valid, isr_valid;
    logic [SW-1:0]   cand_idx, isr_idx;
    logic [RW-1:0]   cand_rank, isr_rank;

    ipc_rank_pick #(.N(NSRC), .RW(RW)) u_pick_req (
        .req_i       (pend & enable),
        .rank_flat_i (rank_flat),
        .valid_o     (cand_valid),
        .idx_o       (cand_idx),
        .rank_o      (cand_rank)
    );

    ipc_rank_pick #(.N(NSRC), .RW(RW)) u_pick_isr (
        .req_i       (isr_q),
        .rank_flat_i (rank_flat),
        .valid_o     (isr_valid),
        .idx_o       (isr_idx),
        .rank_o      (isr_rank)
    );

    logic fwd_valid;
    logic irq_go;

    assign fwd_valid = cand_valid && (!isr_valid || (cand_rank < isr_rank));
    assign irq_go    = fwd_valid && (!poll_mode || (cand_idx == '0));

    // ---------------- handshake FSM ----------------
    hs_state_e     state_q, state_d;
    logic [SW-1:0] held_q;
    logic          held_load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (irq_go) state_d = S_REQ;
            S_REQ: begin
                if (inta_i)       state_d = S_ACKED;
                else if (!irq_go) state_d = S_IDLE;
            end
            S_ACKED: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        irq_o     = 1'b0;
        held_load = 1'b0;
        unique case (state_q)
            S_IDLE:  held_load = irq_go;
            S_REQ: begin
                irq_o     = 1'b1;
                held_load = !inta_i && irq_go;
            end
            S_ACKED: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         held_q <= '0;
        else if (held_load) held_q <= cand_idx;
    end

    assign irq_type_o = VEC_BASE + 8'(held_q);

    // ---------------- commit, in-service, end of interrupt ----------------
    logic          ack_commit, poll_rd, poll_commit, any_commit;
    logic [SW-1:0] commit_src;
    logic [NSRC-1:0] isr_set, isr_clr;

    assign ack_commit  = (state_q == S_REQ) && inta_i;
    assign poll_rd     = reg_rd_i && (reg_addr_e'(reg_addr_i) == A_POLL);
    assign poll_commit = poll_rd && fwd_valid && !ack_commit;
    assign any_commit  = ack_commit || poll_commit;
    assign commit_src  = ack_commit ? held_q : cand_idx;
    assign isr_set     = any_commit ? (NSRC'(1) << commit_src) : '0;
    assign clr_vec     = isr_set;
    assign isr_clr     = (eoi && isr_valid) ? (NSRC'(1) << isr_idx) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr) | isr_set;
    end

    // ---------------- register read ----------------
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_e'(reg_addr_i))
            A_MASK:  reg_rdata_o = DW'(mask);
            A_MODE:  reg_rdata_o = DW'({poll_mode, level_cfg});
            A_PRIA:  reg_rdata_o = DW'(prio_a);
            A_PRIB:  reg_rdata_o = DW'(prio_b);
            A_EOI:   reg_rdata_o = '0;
            A_POLL:  reg_rdata_o = fwd_valid ? {1'b1, (DW-1)'(cand_idx)} : '0;
            A_PEND:  reg_rdata_o = DW'(pend);
            A_INSV:  reg_rdata_o = DW'(isr_q);
            default: reg_rdata_o = '0;
        endcase
    end

    // ---------------- assertions ----------------
    logic [NSRC-1:0] mask_ext;
    assign mask_ext = {mask, 1'b0};

    assert_ack_sets_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REQ && inta_i) |=> isr_q[$past(held_q)])
        else $error("acknowledged source not in service");

    assert_masked_not_offered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REQ && $stable(mask)) |-> !mask_ext[held_q])
        else $error("masked source offered");

    assert_nmi_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && pend[0] && !isr_q[0] && !poll_rd) |=> (state_q == S_REQ && held_q == '0))
        else $error("nmi not offered");

    assert_eoi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_q != '0 && !any_commit) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))))
        else $error("eoi cleared other than one bit");

    assert_ack_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && inta_i) |=> !irq_o)
        else $error("irq held through acknowledge");
endmodule

// File: tb/ipc_nest_ctrl_bench.sv
`timescale 1ns/1ps
module ipc_nest_ctrl_bench;
    localparam int VB = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_drv = '0;
    logic        inta = 1'b0;
    logic        irq;
    logic [7:0]  irq_type;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit mon_hold = 1'b0;
    int exp_q[$];

    always #10 clk = ~clk;

    ipc_nest_ctrl u_ipc_nest_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_i       (src_drv[0]),
        .ext_i       (src_drv[4:1]),
        .dma_i       (src_drv[6:5]),
        .tmr_i       (src_drv[9:7]),
        .inta_i      (inta),
        .irq_o       (irq),
        .irq_type_o  (irq_type),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected sources and acknowledges each offered request
    initial begin
        forever begin
            @(negedge clk);
            if (inta) inta = 1'b0;
            else if (irq && !mon_hold) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected irq", irq_type, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(irq_type == 8'(VB + e), "R8 irq type", irq_type, VB + e);
                end
                inta = 1'b1;
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic read_check(input logic [2:0] a, input logic [15:0] exp, input string req);
        logic [15:0] d;
        reg_read(a, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        src_drv = src_drv | v;
        @(negedge clk);
        src_drv = src_drv & ~v;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 60; i++) begin
            if (exp_q.size() == 0 && !inta) break;
            @(negedge clk);
        end
        if (exp_q.size() != 0) begin
            check(1'b0, req, exp_q.size(), 0);
            exp_q.delete();
        end else begin
            check(1'b1, req, 0, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        check(!seen, req, seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] pria, prib;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        read_check(3'd0, 16'h01FF, "R1 MASK reset");
        read_check(3'd1, 16'h0000, "R1 MODE reset");
        read_check(3'd2, 16'h7FFF, "R1 PRIA reset");
        read_check(3'd3, 16'h0FFF, "R1 PRIB reset");
        read_check(3'd6, 16'h0000, "R1 PEND reset");
        read_check(3'd7, 16'h0000, "R1 INSV reset");

        reg_write(3'd0, 16'h0000);

        // R2 R8: timer0 pulse, acknowledge, EOI
        exp_q.push_back(7);
        pulse(10'b1 << 7);
        drain("R2 timer0 offered");
        read_check(3'd7, 16'h0080, "R8 INSV after ack");
        read_check(3'd6, 16'h0000, "R2 pending cleared by ack");
        reg_write(3'd4, 16'h0);
        read_check(3'd7, 16'h0000, "R9 EOI clears");

        // R5 priorities: src4=2, src5=4, src8=5, src9=1, others 7
        pria = 16'(7 | (7 << 3) | (7 << 6) | (2 << 9) | (4 << 12));
        prib = 16'(7 | (7 << 3) | (5 << 6) | (1 << 9));
        reg_write(3'd2, pria);
        reg_write(3'd3, prib);

        exp_q.push_back(9);
        pulse((10'b1 << 5) | (10'b1 << 9));
        drain("R5 most urgent first");
        quiet(10, "R7 lower rank waits");
        read_check(3'd6, 16'h0020, "R2 dma0 still pending");
        exp_q.push_back(5);
        reg_write(3'd4, 16'h0);
        drain("R7 dma0 after EOI");
        reg_write(3'd4, 16'h0);

        // R5 tie: src1 and src6 both priority 7
        exp_q.push_back(1);
        pulse((10'b1 << 1) | (10'b1 << 6));
        drain("R5 tie lower index");
        quiet(8, "R7 equal rank not nested");
        exp_q.push_back(6);
        reg_write(3'd4, 16'h0);
        drain("R5 tie second");
        reg_write(3'd4, 16'h0);
        read_check(3'd7, 16'h0000, "R9 all retired");

        // R7 nesting: src8 then more urgent src4
        exp_q.push_back(8);
        pulse(10'b1 << 8);
        drain("R7 first handler");
        exp_q.push_back(4);
        pulse(10'b1 << 4);
        drain("R7 nested handler");
        read_check(3'd7, 16'h0110, "R7 two in service");
        reg_write(3'd4, 16'h0);
        read_check(3'd7, 16'h0100, "R9 EOI retires most urgent");
        reg_write(3'd4, 16'h0);

        // R4 masking
        reg_write(3'd0, 16'h0040);
        pulse(10'b1 << 7);
        quiet(10, "R4 masked not offered");
        read_check(3'd6, 16'h0080, "R4 masked still pending");
        exp_q.push_back(7);
        reg_write(3'd0, 16'h0000);
        drain("R4 unmasked offered");
        reg_write(3'd4, 16'h0);

        // R6 nmi with all masked
        reg_write(3'd0, 16'h01FF);
        exp_q.push_back(0);
        pulse(10'b1);
        drain("R6 nmi ignores mask");
        read_check(3'd7, 16'h0001, "R6 nmi in service");
        reg_write(3'd4, 16'h0);
        reg_write(3'd0, 16'h0000);

        // R3 R12 level mode on external pin 0
        reg_write(3'd1, 16'h0001);
        mon_hold = 1'b1;
        @(negedge clk);
        src_drv[1] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (irq) break;
            @(negedge clk);
        end
        check(irq == 1'b1 && irq_type == 8'(VB + 1), "R3 level offered", irq_type, VB + 1);
        src_drv[1] = 1'b0;
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R12 withdraw", irq, 0);
        mon_hold = 1'b0;
        read_check(3'd6, 16'h0000, "R3 pending follows low pin");
        exp_q.push_back(1);
        @(negedge clk);
        src_drv[1] = 1'b1;
        drain("R3 level acknowledged");
        read_check(3'd6, 16'h0002, "R3 ack keeps level pending");
        src_drv[1] = 1'b0;
        reg_write(3'd4, 16'h0);
        quiet(8, "R3 no request after drop");
        read_check(3'd6, 16'h0000, "R3 pending clears with pin");

        // R10 R11 polled mode
        reg_write(3'd1, 16'h0010);
        pulse(10'b1 << 9);
        quiet(8, "R10 no irq in polled mode");
        read_check(3'd5, 16'h8009, "R11 poll returns source");
        read_check(3'd7, 16'h0200, "R11 poll marks in service");
        read_check(3'd6, 16'h0000, "R11 poll clears pending");
        read_check(3'd5, 16'h0000, "R11 empty poll");
        reg_write(3'd4, 16'h0);
        exp_q.push_back(0);
        pulse(10'b1);
        drain("R6 nmi in polled mode");
        reg_write(3'd4, 16'h0);
        read_check(3'd7, 16'h0000, "R9 final in service empty");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule